// File: doc/BRIEF.md
# Serial Port Register Front End with Receive FIFO

This block sits between a processor bus and a character-level serial engine. Software sees six byte-wide registers on a small address space: a mode register, a control register, a transmit data register, a status register, a receive data register and a FIFO control register. Received characters arrive as whole bytes with a valid strobe and are queued in a 16-entry FIFO. Characters written by software leave as whole bytes with a one-cycle strobe. Bit timing, baud generation, parity and framing are handled elsewhere.

The status register uses write-zero-to-clear semantics. The receive-full flag is tied to a programmable fill threshold. Reading status while the transmitter is enabled re-arms the two transmit-empty flags. A receive interrupt follows the threshold and the receive interrupt enable. The transmit interrupt line mirrors a control bit.

Register indices on `bus_addr` are: 0 mode, 1 control, 2 transmit data, 3 status, 4 receive data, 5 FIFO control. A read is `bus_en` with `bus_we` low, and its data is valid on `bus_rdata` in the same cycle. A write is `bus_en` with `bus_we` high. Read side effects take place at the clock edge that ends the access.

Top module: `serial_front_end`

## Requirements
- R1: After reset, the registers read as follows: mode (index 0) 0x00, control (index 1) 0x20, status (index 3) 0x60, FIFO control (index 5) 0x00 (trigger level 1). Both interrupt outputs are low.
- R2: A write to mode stores the value ANDed with 0x7B. A write to control stores the value ANDed with 0xFA. Both read back the stored value.
- R3: The receive FIFO holds 16 bytes and returns them in arrival order. A byte offered while 16 are held is dropped, and the held bytes are unaffected.
- R4: A byte on `rx_data` with `rx_valid` is taken only while control bit 4 (receive enable) is 1.
- R5: When a taken byte leaves the fill count at or above the trigger level, status bit 1 (receive full) becomes 1. If control bit 6 (receive interrupt enable) is also 1, `irq_rx` goes high on the next cycle.
- R6: Reading receive data (index 4) returns the oldest byte and removes it. If the count then falls below the trigger level, status bit 1 clears. A read of an empty FIFO returns 0 and changes nothing.
- R7: A status write clears each of bits 6 (transmit end), 5 (transmit empty) and 1 (receive full) that is written as 0. Bits written as 1 are left unchanged. If bit 1 or bit 0 is written as 0, `irq_rx` drops. Status bits 4 and 0 always read 0.
- R8: `irq_tx` equals control bit 7. A control write with bit 6 = 0 drops `irq_rx`. A control write with bit 5 = 0 sets status bit 6.
- R9: A write to transmit data (index 2) drives that byte on `tx_data` with `tx_strobe` high for exactly the next cycle, and clears status bit 5.
- R10: A status read returns the flags held before the read. If control bit 5 (transmit enable) is 1, status bits 5 and 6 are both set after the read.
- R11: A FIFO control write with bit 1 = 1 empties the receive FIFO and leaves the status flags unchanged. Bits 7:6 select the trigger level (00 = 1, 01 = 4, 10 = 8, 11 = 14) and read back in place, while the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| tx_strobe | output | 1 | Transmit byte valid (one cycle) |
| tx_data | output | 8 | Transmit byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench goes after the full-FIFO boundary. A design with an off-by-one count would either store a seventeenth byte or corrupt the oldest one, and the ordered drain would show it. It also sweeps all four trigger encodings with the receive-full flag and interrupt observed one byte before and at the threshold, where a wrong comparison sets the flag early or late. Write-one-to-status must leave flags alone, and a design that treats the write as plain data would wipe them. The status read must return the pre-read flags before re-arming, so an ordering mistake shows the re-armed value too early. An empty-FIFO read must return 0 without moving pointers, which would otherwise desynchronise every later byte.

// File: rtl/serial_fe_pkg.sv
package serial_fe_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE = 3'd0,
        REG_CTRL = 3'd1,
        REG_TXD  = 3'd2,
        REG_STAT = 3'd3,
        REG_RXD  = 3'd4,
        REG_FCTL = 3'd5
    } reg_sel_e;

    localparam logic [DATA_W-1:0] MODE_WMASK = 8'h7B;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'hFA;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h20;

    localparam int unsigned CTRL_TXIE = 7;
    localparam int unsigned CTRL_RXIE = 6;
    localparam int unsigned CTRL_TE   = 5;
    localparam int unsigned CTRL_RE   = 4;

    localparam int unsigned ST_TEND = 6;
    localparam int unsigned ST_TDE  = 5;
    localparam int unsigned ST_RDF  = 1;
    localparam int unsigned ST_DR   = 0;

    localparam int unsigned FCTL_FLUSH = 1;
    localparam int unsigned FCTL_TRG_LO = 6;

    typedef struct packed {
        logic tend;
        logic tde;
        logic rdf;
    } stat_flags_t;

    typedef struct packed {
        logic wr_mode;
        logic wr_ctrl;
        logic wr_txd;
        logic wr_stat;
        logic wr_fctl;
        logic rd_stat;
        logic rd_rxd;
    } bus_strobe_t;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input stat_flags_t f);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[ST_TEND] = f.tend;
        v[ST_TDE]  = f.tde;
        v[ST_RDF]  = f.rdf;
        return v;
    endfunction

    function automatic bus_strobe_t decode_bus(input logic en, input logic we,
                                               input reg_sel_e sel);
        bus_strobe_t s;
        s         = '0;
        s.wr_mode = en &&  we && (sel == REG_MODE);
        s.wr_ctrl = en &&  we && (sel == REG_CTRL);
        s.wr_txd  = en &&  we && (sel == REG_TXD);
        s.wr_stat = en &&  we && (sel == REG_STAT);
        s.wr_fctl = en &&  we && (sel == REG_FCTL);
        s.rd_stat = en && !we && (sel == REG_STAT);
        s.rd_rxd  = en && !we && (sel == REG_RXD);
        return s;
    endfunction

endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             push_taken,
    output logic             pop_taken,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nxt
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic             full, empty;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full       = (count_q == CNT_W'(DEPTH));
    assign empty      = (count_q == '0);
    assign push_taken = push && !flush && !full;
    assign pop_taken  = pop && !flush && !empty;
    assign head_data  = empty ? '0 : mem[rd_ptr_q];

    always_comb begin
        if (flush) begin
            count_nxt = '0;
        end else begin
            count_nxt = count_q + CNT_W'(push_taken) - CNT_W'(pop_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            count_q <= count_nxt;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (push_taken) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (pop_taken)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_taken) mem[wr_ptr_q] <= push_data;
    end

endmodule

// File: rtl/serial_fe_cfg.sv
module serial_fe_cfg
    import serial_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_strobe_t       stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [1:0]        trig_sel_q,
    output logic              flush,
    output logic [DATA_W-1:0] tx_data_q,
    output logic              tx_strobe_q
);

    assign flush = stb.wr_fctl && wdata[FCTL_FLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            ctrl_q      <= CTRL_RESET;
            trig_sel_q  <= 2'b00;
            tx_data_q   <= '0;
            tx_strobe_q <= 1'b0;
        end else begin
            tx_strobe_q <= stb.wr_txd;
            if (stb.wr_mode) mode_q     <= wdata & MODE_WMASK;
            if (stb.wr_ctrl) ctrl_q     <= wdata & CTRL_WMASK;
            if (stb.wr_fctl) trig_sel_q <= wdata[FCTL_TRG_LO +: 2];
            if (stb.wr_txd)  tx_data_q  <= wdata;
        end
    end

endmodule

// File: rtl/serial_fe_status.sv
module serial_fe_status
    import serial_fe_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_strobe_t       stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [CNT_W-1:0]  trig,
    input  logic              push_taken,
    input  logic              pop_taken,
    input  logic [CNT_W-1:0]  count_nxt,
    output stat_flags_t       flags_q,
    output logic              irq_rx_q
);

    stat_flags_t flags_d;
    logic        irq_d;
    logic        irq_clr;
    logic        rxie_eff;
    logic        at_trig;

    assign at_trig  = (count_nxt >= trig);
    assign rxie_eff = stb.wr_ctrl ? wdata[CTRL_RXIE] : ctrl_q[CTRL_RXIE];
    assign irq_clr  = (stb.wr_ctrl && !wdata[CTRL_RXIE]) ||
                      (stb.wr_stat && (!wdata[ST_RDF] || !wdata[ST_DR]));

    always_comb begin
        flags_d = flags_q;
        if (stb.rd_stat && ctrl_q[CTRL_TE]) begin
            flags_d.tde  = 1'b1;
            flags_d.tend = 1'b1;
        end
        if (stb.wr_stat) begin
            if (!wdata[ST_TEND]) flags_d.tend = 1'b0;
            if (!wdata[ST_TDE])  flags_d.tde  = 1'b0;
            if (!wdata[ST_RDF])  flags_d.rdf  = 1'b0;
        end
        if (stb.wr_ctrl && !wdata[CTRL_TE]) flags_d.tend = 1'b1;
        if (stb.wr_txd) flags_d.tde = 1'b0;
        if (pop_taken && !at_trig) flags_d.rdf = 1'b0;
        if (push_taken && at_trig) flags_d.rdf = 1'b1;
    end

    always_comb begin
        irq_d = irq_rx_q;
        if (irq_clr) begin
            irq_d = 1'b0;
        end else if (push_taken && at_trig && rxie_eff) begin
            irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '{tend: 1'b1, tde: 1'b1, rdf: 1'b0};
            irq_rx_q <= 1'b0;
        end else begin
            flags_q  <= flags_d;
            irq_rx_q <= irq_d;
        end
    end

endmodule

// File: rtl/serial_front_end.sv
module serial_front_end
    import serial_fe_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_strobe,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq_rx,
    output logic              irq_tx
);

    reg_sel_e          sel;
    bus_strobe_t       stb;
    logic [DATA_W-1:0] mode_q, ctrl_q, head_data;
    logic [1:0]        trig_sel_q;
    logic              flush, push_taken, pop_taken;
    logic [CNT_W-1:0]  fill_cnt, count_nxt, trig;
    stat_flags_t       flags_q;

    assign sel  = reg_sel_e'(bus_addr);
    assign stb  = decode_bus(bus_en, bus_we, sel);
    assign trig = CNT_W'(trig_level(trig_sel_q));

    serial_fe_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .stb         (stb),
        .wdata       (bus_wdata),
        .mode_q      (mode_q),
        .ctrl_q      (ctrl_q),
        .trig_sel_q  (trig_sel_q),
        .flush       (flush),
        .tx_data_q   (tx_data),
        .tx_strobe_q (tx_strobe)
    );

    rx_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (rx_valid && ctrl_q[CTRL_RE]),
        .push_data  (rx_data),
        .pop        (stb.rd_rxd),
        .head_data  (head_data),
        .push_taken (push_taken),
        .pop_taken  (pop_taken),
        .count_q    (fill_cnt),
        .count_nxt  (count_nxt)
    );

    serial_fe_status #(
        .CNT_W (CNT_W)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .stb        (stb),
        .wdata      (bus_wdata),
        .ctrl_q     (ctrl_q),
        .trig       (trig),
        .push_taken (push_taken),
        .pop_taken  (pop_taken),
        .count_nxt  (count_nxt),
        .flags_q    (flags_q),
        .irq_rx_q   (irq_rx)
    );

    assign irq_tx = ctrl_q[CTRL_TXIE];

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                REG_MODE: bus_rdata = mode_q;
                REG_CTRL: bus_rdata = ctrl_q;
                REG_STAT: bus_rdata = pack_status(flags_q);
                REG_RXD:  bus_rdata = head_data;
                REG_FCTL: bus_rdata = {trig_sel_q, 6'b0};
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/serial_fe_checker.sv
module serial_fe_checker
    import serial_fe_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              tx_strobe,
    input logic [DATA_W-1:0] tx_data,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic [CNT_W-1:0]  fill,
    input logic [DATA_W-1:0] ctrl_q,
    input stat_flags_t       flags_q
);

    logic wr_ctrl, wr_txd, wr_stat, wr_fctl, rd_stat, rd_rxd;
    assign wr_ctrl = bus_en &&  bus_we && (bus_addr == REG_CTRL);
    assign wr_txd  = bus_en &&  bus_we && (bus_addr == REG_TXD);
    assign wr_stat = bus_en &&  bus_we && (bus_addr == REG_STAT);
    assign wr_fctl = bus_en &&  bus_we && (bus_addr == REG_FCTL);
    assign rd_stat = bus_en && !bus_we && (bus_addr == REG_STAT);
    assign rd_rxd  = bus_en && !bus_we && (bus_addr == REG_RXD);

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (fill == CNT_W'(DEPTH) && rx_valid && !rd_rxd && !wr_fctl) |=> fill == CNT_W'(DEPTH));

    assert_rx_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[CTRL_RE] && !wr_ctrl && !rd_rxd && !wr_fctl) |=> fill == $past(fill));

    assert_stat_clear_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && (!bus_wdata[ST_RDF] || !bus_wdata[ST_DR])) |=> !irq_rx);

    assert_irq_tx_follows_R8: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> irq_tx == $past(bus_wdata[CTRL_TXIE]));

    assert_rxie_off_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !bus_wdata[CTRL_RXIE]) |=> !irq_rx);

    assert_tx_out_R9: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> (tx_strobe && tx_data == $past(bus_wdata)));

    assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_txd |=> !tx_strobe);

    assert_rearm_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && ctrl_q[CTRL_TE]) |=> (flags_q.tde && flags_q.tend));

endmodule

bind serial_front_end serial_fe_checker #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .tx_strobe (tx_strobe),
    .tx_data   (tx_data),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .fill      (fill_cnt),
    .ctrl_q    (ctrl_q),
    .flags_q   (flags_q)
);

// File: tb/serial_front_end_bench.sv
module serial_front_end_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_strobe;
    logic [7:0] tx_data;
    logic       irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_mode, m_ctrl;
    logic [1:0] m_trig;
    logic       m_tend, m_tde, m_rdf, m_irq;
    logic [7:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_front_end u_serial_front_end (
        .clk (clk), .rst (rst),
        .bus_en (bus_en), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rx_valid (rx_valid), .rx_data (rx_data),
        .tx_strobe (tx_strobe), .tx_data (tx_data),
        .irq_rx (irq_rx), .irq_tx (irq_tx)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {1'b0, m_tend, m_tde, 3'b000, m_rdf, 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic check_irqs(input string req);
        check({req, " irq_rx"}, {7'b0, irq_rx}, {7'b0, m_irq});
        check({req, " irq_tx"}, {7'b0, irq_tx}, {7'b0, m_ctrl[7]});
    endtask

    task automatic do_wr_ctrl(input logic [7:0] d);
        bus_write(3'd1, d);
        m_ctrl = d & 8'hFA;
        if (!d[5]) m_tend = 1'b1;
        if (!d[6]) m_irq = 1'b0;
        check_irqs("R8");
    endtask

    task automatic do_wr_mode(input logic [7:0] d);
        logic [7:0] r;
        bus_write(3'd0, d);
        m_mode = d & 8'h7B;
        bus_read(3'd0, r);
        check("R2 mode", r, m_mode);
    endtask

    task automatic do_wr_stat(input logic [7:0] d);
        bus_write(3'd3, d);
        if (!d[6]) m_tend = 1'b0;
        if (!d[5]) m_tde = 1'b0;
        if (!d[1]) m_rdf = 1'b0;
        if (!d[1] || !d[0]) m_irq = 1'b0;
        check_irqs("R7");
    endtask

    task automatic do_wr_fctl(input logic [7:0] d);
        bus_write(3'd5, d);
        m_trig = d[7:6];
        if (d[1]) q.delete();
    endtask

    task automatic do_tx(input logic [7:0] d);
        bus_write(3'd2, d);
        check("R9 strobe", {7'b0, tx_strobe}, 8'h01);
        check("R9 data", tx_data, d);
        m_tde = 1'b0;
        @(negedge clk);
        check("R9 pulse", {7'b0, tx_strobe}, 8'h00);
    endtask

    task automatic do_rd_stat();
        logic [7:0] r;
        bus_read(3'd3, r);
        check("R10 status", r, exp_status());
        if (m_ctrl[5]) begin m_tde = 1'b1; m_tend = 1'b1; end
    endtask

    task automatic do_rd_rx();
        logic [7:0] r, e;
        bus_read(3'd4, r);
        if (q.size() == 0) begin
            e = 8'h00;
        end else begin
            e = q.pop_front();
            if (q.size() < trig_of(m_trig)) m_rdf = 1'b0;
        end
        check("R6 rxdata", r, e);
    endtask

    task automatic do_push(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
        if (m_ctrl[4] && q.size() < DEPTH) begin
            q.push_back(d);
            if (q.size() >= trig_of(m_trig)) begin
                m_rdf = 1'b1;
                if (m_ctrl[6]) m_irq = 1'b1;
            end
        end
        check_irqs("R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_0042));
        m_mode = 8'h00; m_ctrl = 8'h20; m_trig = 2'b00;
        m_tend = 1'b1; m_tde = 1'b1; m_rdf = 1'b0; m_irq = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(3'd0, r); check("R1 mode", r, 8'h00);
        bus_read(3'd1, r); check("R1 ctrl", r, 8'h20);
        bus_read(3'd5, r); check("R1 fctl", r, 8'h00);
        bus_read(3'd3, r); check("R1 status", r, 8'h60);
        check_irqs("R1");

        // R2 masks
        do_wr_mode(8'hFF);
        bus_write(3'd1, 8'hFF); m_ctrl = 8'hFA;
        bus_read(3'd1, r); check("R2 ctrl", r, 8'hFA);
        check_irqs("R8");

        // R4: receive disabled drops bytes
        do_wr_ctrl(8'h60);
        do_push(8'hA1);
        do_rd_rx();
        check("R4 empty", {7'b0, m_rdf}, 8'h00);

        // R3 fill 16, drop 17th, drain in order
        do_wr_ctrl(8'h70);
        do_wr_fctl(8'hC0);
        for (int i = 0; i < 17; i++) do_push(8'h10 + 8'(i));
        do_rd_stat();
        for (int i = 0; i < 17; i++) do_rd_rx();
        check("R3 drained", 8'(q.size()), 8'h00);

        // R5/R11: every trigger level, flag one before and at threshold
        for (int s = 0; s < 4; s++) begin
            do_wr_stat(8'hFC);
            do_wr_fctl({2'(s), 6'b000010});
            bus_read(3'd5, r); check("R11 fctl", r, {2'(s), 6'b0});
            for (int i = 0; i < trig_of(2'(s)); i++) begin
                do_rd_stat();
                do_push(8'(s * 16 + i));
            end
            do_rd_stat();
            check("R5 irq at trig", {7'b0, irq_rx}, 8'h01);
            do_rd_rx();
            do_rd_stat();
        end

        // R11 flush keeps flags
        do_wr_fctl(8'h02);
        do_rd_stat();
        do_rd_rx();

        // R7 ones leave flags; zeros clear
        do_wr_ctrl(8'h10);
        do_push(8'h55);
        do_wr_stat(8'hFF); do_rd_stat();
        do_wr_stat(8'h00); do_rd_stat();

        // R9/R10 transmit with TE off, then re-arm
        do_wr_ctrl(8'h10);
        do_tx(8'h3C);
        do_rd_stat();
        do_wr_ctrl(8'h30);
        do_rd_stat();
        do_rd_stat();

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] v;
            op = int'($urandom_range(0, 99));
            v  = 8'($urandom);
            if (op < 35)      do_push(v);
            else if (op < 55) do_rd_rx();
            else if (op < 68) do_rd_stat();
            else if (op < 76) do_wr_stat(v | 8'h9C);
            else if (op < 84) do_wr_ctrl(v | 8'h10);
            else if (op < 88) do_wr_fctl(v & (($urandom_range(0, 7) == 0) ? 8'hC2 : 8'hC0));
            else if (op < 94) do_tx(v);
            else              do_wr_mode(v);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule